// File: doc/BRIEF.md
# I2C Controller Interrupt Status Block

This block collects the interrupt events of an I2C controller. Ten of the twelve sources are sticky. A one-cycle pulse on the matching event input sets the bit, and the bit stays set until software clears it. The other two sources, receive-full and transmit-empty, are levels. They follow the FIFO threshold inputs directly and cannot be cleared. A mask register gates the raw status into a masked status, and the interrupt line is the OR of the masked bits.

Software clears a sticky event by reading that event's own clear address. A separate address clears every sticky event in one read. When a transfer aborts, the block collects the reasons into an abort-cause register and sends a one-cycle flush pulse to the FIFOs. Reading the abort clear address, or the clear-all address, also empties the abort-cause register. Any event or cause that arrives in the same cycle as the read that would clear it is kept.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: A pulse on evt_i[k] for a sticky bit k (every k except 2 and 4) sets bit k of the raw status word at address 0x04. The bit stays set until it is cleared. The bit order is: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop, 10 start, 11 general call.
- R2: Raw bits 2 and 4 equal evt_i[2] and evt_i[4] in the same cycle. Reading their clear addresses (0x28 and 0x30) has no effect on them.
- R3: The mask register at 0x08 is written through wr_en_i from wdata_i[11:0] and can be read back. The masked status at 0x00 reads as raw status AND mask.
- R4: irq_o is high exactly when any masked status bit is set.
- R5: A read (rd_en_i) at address 0x20+4k clears sticky bit k at the next edge and leaves all other bits alone. The read returns the bit's value before the read in bit 0.
- R6: A read at 0x14 clears every sticky bit and the abort-cause register.
- R7: An event that arrives in the same cycle as a read that would clear its bit leaves the bit set.
- R8: In a cycle with evt_i[6] high, the bits of abrt_cause_i are ORed into the abort-cause register at 0x0C. Cause bits 6 and 8 are reserved and always read 0.
- R9: A read of the tx-abort clear address 0x38 empties the abort-cause register. Cause bits that arrive in that same cycle are kept.
- R10: Bit 0 of the bus status word at 0x10 equals bus_active_i.
- R11: flush_o is high for exactly the cycle after each cycle in which evt_i[6] is high.
- R12: After reset, raw sticky bits, mask, abort cause, irq_o and flush_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| rd_en_i | input | 1 | Read strobe; triggers read side effects |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| evt_i | input | 12 | Event pulses (sticky bits) and FIFO levels (bits 2, 4) |
| abrt_cause_i | input | 13 | Abort reasons, sampled with evt_i[6] |
| bus_active_i | input | 1 | Bus activity level |
| irq_o | output | 1 | Interrupt request |
| flush_o | output | 1 | FIFO flush pulse after an abort |

## Verification
Two actions can land in the same cycle: a new event and the read that clears that event's bit, or new abort causes and the read that empties the cause register. Directed steps drive the event or cause together with the matching clear read. On the next read, the event bit must still be set and the new cause bits must be present, while the older cause bits are gone. The random phase drives sparse event vectors and reads from random addresses at the same time, so these overlaps also occur by chance. It compares every read word and the interrupt line against a bench model that applies the set-wins rule.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned NUM_EVT = 12;
  localparam int unsigned ABRT_W  = 13;

  localparam int unsigned EV_RX_FULL  = 2;
  localparam int unsigned EV_TX_EMPTY = 4;
  localparam int unsigned EV_TX_ABORT = 6;

  localparam logic [NUM_EVT-1:0] LEVEL_MASK = 12'h014;
  localparam logic [ABRT_W-1:0]  ABRT_VALID = 13'h1EBF;

  localparam int unsigned A_MASKED   = 'h00;
  localparam int unsigned A_RAW      = 'h04;
  localparam int unsigned A_MASK     = 'h08;
  localparam int unsigned A_CAUSE    = 'h0C;
  localparam int unsigned A_BUS      = 'h10;
  localparam int unsigned A_CLR_ALL  = 'h14;
  localparam int unsigned A_CLR_BASE = 'h20;
endpackage

// File: rtl/i2c_irq_event_bank.sv
module i2c_irq_event_bank
  import i2c_irq_pkg::*;
#(
  parameter int unsigned N = NUM_EVT,
  parameter logic [N-1:0] LEVEL = LEVEL_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         clr_all_i,
  output logic [N-1:0] raw_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LEVEL[i]) begin : g_lvl
      assign raw_o[i] = evt_i[i];
      // decoder must never aim a clear at a level source
      p_noclr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) !clr_i[i]);
    end else begin : g_stk
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   q <= 1'b0;
        else if (evt_i[i])             q <= 1'b1;  // set wins over clear
        else if (clr_i[i] || clr_all_i) q <= 1'b0;
      end
      assign raw_o[i] = q;

      p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw_o[i] && !clr_i[i] && !clr_all_i) |=> raw_o[i]);
      p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !evt_i[i]) |=> !raw_o[i]);
      p_same_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[i] && (clr_i[i] || clr_all_i)) |=> raw_o[i]);
    end
  end

endmodule

// File: rtl/i2c_irq_abort_cause.sv
module i2c_irq_abort_cause
  import i2c_irq_pkg::*;
#(
  parameter int unsigned W = ABRT_W,
  parameter logic [W-1:0] VALID = ABRT_VALID
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         abort_i,
  input  logic [W-1:0] cause_i,
  input  logic         clr_i,
  output logic [W-1:0] cause_o,
  output logic         flush_o
);

  logic [W-1:0] cause_q;
  logic [W-1:0] new_bits;
  logic         flush_q;

  assign new_bits = abort_i ? (cause_i & VALID) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      flush_q <= 1'b0;
    end else begin
      cause_q <= (clr_i ? '0 : cause_q) | new_bits;
      flush_q <= abort_i;
    end
  end

  assign cause_o = cause_q;
  assign flush_o = flush_q;

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> flush_o);
  p_flush_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i |=> !flush_o);
  p_cause_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !abort_i) |=> (cause_o == '0));
  p_cause_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && cause_i[0]) |=> cause_o[0]);

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = NUM_EVT,
  parameter int unsigned W      = ABRT_W,
  parameter logic [N-1:0] LEVEL = LEVEL_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      raw_i,
  input  logic [W-1:0]      cause_i,
  input  logic              bus_active_i,
  output logic [N-1:0]      masked_o,
  output logic [N-1:0]      clr_o,
  output logic              clr_all_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [N-1:0] mask_q;
  logic         unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i[N-1:0];
  end

  assign masked_o  = raw_i & mask_q;
  assign clr_all_o = rd_en_i && (addr_i == ADDR_W'(A_CLR_ALL));

  for (genvar i = 0; i < N; i++) begin : g_clr
    if (LEVEL[i]) begin : g_none
      assign clr_o[i] = 1'b0;
    end else begin : g_dec
      assign clr_o[i] = rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + 4 * i));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_MASKED): rdata_o[N-1:0] = masked_o;
      ADDR_W'(A_RAW):    rdata_o[N-1:0] = raw_i;
      ADDR_W'(A_MASK):   rdata_o[N-1:0] = mask_q;
      ADDR_W'(A_CAUSE):  rdata_o[W-1:0] = cause_i;
      ADDR_W'(A_BUS):    rdata_o[0]     = bus_active_i;
      default: begin
        for (int i = 0; i < int'(N); i++)
          if (addr_i == ADDR_W'(A_CLR_BASE + 4 * i)) rdata_o[0] = raw_i[i];
      end
    endcase
  end

  p_mask_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ABRT_W-1:0] abrt_cause_i,
  input  logic              bus_active_i,
  output logic              irq_o,
  output logic              flush_o
);

  logic [NUM_EVT-1:0] raw;
  logic [NUM_EVT-1:0] masked;
  logic [NUM_EVT-1:0] clr;
  logic               clr_all;
  logic [ABRT_W-1:0]  cause;

  i2c_irq_event_bank #(.N(NUM_EVT), .LEVEL(LEVEL_MASK)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .clr_i     (clr),
    .clr_all_i (clr_all),
    .raw_o     (raw)
  );

  i2c_irq_abort_cause #(.W(ABRT_W), .VALID(ABRT_VALID)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (evt_i[EV_TX_ABORT]),
    .cause_i (abrt_cause_i),
    .clr_i   (clr[EV_TX_ABORT] | clr_all),
    .cause_o (cause),
    .flush_o (flush_o)
  );

  i2c_irq_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NUM_EVT), .W(ABRT_W), .LEVEL(LEVEL_MASK)
  ) u_regif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .rd_en_i      (rd_en_i),
    .wr_en_i      (wr_en_i),
    .wdata_i      (wdata_i),
    .raw_i        (raw),
    .cause_i      (cause),
    .bus_active_i (bus_active_i),
    .masked_o     (masked),
    .clr_o        (clr),
    .clr_all_o    (clr_all),
    .rdata_o      (rdata_o)
  );

  assign irq_o = |masked;

  p_irq_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[EV_TX_ABORT] && rdata_o[EV_TX_ABORT] && addr_i == ADDR_W'(A_MASK) && !wr_en_i)
    |=> irq_o);
  p_clr_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(A_CLR_ALL) && evt_i == '0)
    |=> ((raw & ~LEVEL_MASK) == '0 && cause == '0));

endmodule

// File: tb/i2c_irq_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_irq_ctrl_tb;
  import i2c_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] evt = '0;
  logic [12:0] cause_in = '0;
  logic        bus_act = 1'b0;
  logic        irq, flush;

  int checks = 0;
  int errors = 0;

  logic [11:0] m_sticky = '0;
  logic [11:0] m_mask   = '0;
  logic [12:0] m_cause  = '0;
  logic        m_prev_abort = 1'b0;

  always #10 clk = ~clk;

  i2c_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .abrt_cause_i(cause_in),
    .bus_active_i(bus_act), .irq_o(irq), .flush_o(flush)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] m_raw(input logic [11:0] e);
    return m_sticky | (e & 12'h014);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a, input logic [11:0] e, input logic b);
    logic [11:0] r = m_raw(e);
    case (a)
      8'h00: return {20'd0, r & m_mask};
      8'h04: return {20'd0, r};
      8'h08: return {20'd0, m_mask};
      8'h0C: return {19'd0, m_cause};
      8'h10: return {31'd0, b};
      default: begin
        for (int i = 0; i < 12; i++)
          if (a == 8'(8'h20 + 4 * i)) return {31'd0, r[i]};
        return 32'd0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00:   return "R3 masked";
      8'h04:   return "R1 raw";
      8'h08:   return "R3 mask";
      8'h0C:   return "R8 cause";
      8'h10:   return "R10 bus";
      8'h14:   return "R6 clrall";
      default: return "R5 clr";
    endcase
  endfunction

  task automatic cycle(input string tag, input logic [7:0] a, input logic rd, input logic wr,
                       input logic [31:0] wd, input logic [11:0] e, input logic [12:0] c,
                       input logic b);
    logic [11:0] clr;
    logic        clr_all;
    @(negedge clk);
    addr = a; rd_en = rd; wr_en = wr; wdata = wd; evt = e; cause_in = c; bus_act = b;
    #2;
    chk((tag == "") ? tag_of(a) : tag, rdata, m_read(a, e, b));
    chk((tag == "") ? "R4 irq" : tag, {31'd0, irq}, {31'd0, |(m_raw(e) & m_mask)});
    chk((tag == "") ? "R11 flush" : tag, {31'd0, flush}, {31'd0, m_prev_abort});
    @(posedge clk);
    clr = '0;
    for (int i = 0; i < 12; i++)
      if (i != 2 && i != 4 && rd && a == 8'(8'h20 + 4 * i)) clr[i] = 1'b1;
    clr_all = rd && a == 8'h14;
    m_cause  = ((clr[6] || clr_all) ? 13'd0 : m_cause) | (e[6] ? (c & 13'h1EBF) : 13'd0);
    m_sticky = (m_sticky & ~(clr | {12{clr_all}})) | (e & ~12'h014);
    if (wr && a == 8'h08) m_mask = wd[11:0];
    m_prev_abort = e[6];
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cycle(tag, a, 1'b1, 1'b0, 32'd0, 12'd0, 13'd0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd("R12 raw", 8'h04);
    rd("R12 mask", 8'h08);
    rd("R12 cause", 8'h0C);
    rd("R12 masked", 8'h00);

    // R1 sticky set, R3 mask write, R4 irq
    cycle("R1 set", 8'h00, 1'b0, 1'b0, 0, 12'h001, 0, 1'b0);
    rd("R1 hold", 8'h04);
    cycle("R3 wr", 8'h08, 1'b0, 1'b1, 32'hFFFF_F801, 0, 0, 1'b0);
    rd("R3 readback", 8'h08);
    rd("R4 irq on", 8'h00);
    rd("R5 clr0", 8'h20);
    rd("R5 after", 8'h04);

    // R7 event same cycle as its clear
    cycle("R1 set9", 8'h00, 1'b0, 1'b0, 0, 12'h200, 0, 1'b0);
    cycle("R7 race", 8'h44, 1'b1, 1'b0, 0, 12'h200, 0, 1'b0);
    rd("R7 kept", 8'h04);
    rd("R5 clr9", 8'h44);
    rd("R5 gone", 8'h04);

    // R2 level bits ignore clear reads
    cycle("R2 lvl", 8'h28, 1'b1, 1'b0, 0, 12'h014, 0, 1'b0);
    cycle("R2 lvl2", 8'h30, 1'b1, 1'b0, 0, 12'h014, 0, 1'b0);
    cycle("R2 still", 8'h04, 1'b1, 1'b0, 0, 12'h014, 0, 1'b0);
    rd("R2 drop", 8'h04);

    // R8 cause with reserved bits, R11 flush
    cycle("R8 abort", 8'h00, 1'b0, 1'b0, 0, 12'h040, 13'h1FFF, 1'b0);
    rd("R8 cause", 8'h0C);
    rd("R11 quiet", 8'h0C);
    // R9 clear with new cause in same cycle
    cycle("R9 race", 8'h38, 1'b1, 1'b0, 0, 12'h040, 13'h0001, 1'b0);
    rd("R9 cause", 8'h0C);
    rd("R9 raw", 8'h04);
    rd("R9 clr", 8'h38);
    rd("R9 empty", 8'h0C);

    // R6 clear all
    cycle("R6 fill", 8'h00, 1'b0, 1'b0, 0, 12'hFEB, 13'h0808, 1'b0);
    rd("R6 clr", 8'h14);
    rd("R6 raw", 8'h04);
    rd("R6 cause", 8'h0C);

    // R10 bus activity
    cycle("R10 hi", 8'h10, 1'b0, 1'b0, 0, 0, 0, 1'b1);
    cycle("R10 lo", 8'h10, 1'b0, 1'b0, 0, 0, 0, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [31:0] r = $urandom;
      case (r[4:0])
        5'd0:  a = 8'h00;
        5'd1:  a = 8'h04;
        5'd2:  a = 8'h08;
        5'd3:  a = 8'h0C;
        5'd4:  a = 8'h10;
        5'd5:  a = 8'h14;
        5'd6:  a = 8'($urandom);
        default: a = 8'(8'h20 + 4 * (r[8:5] % 12));
      endcase
      cycle("", a, r[9], (r[12:10] == 3'd0), $urandom,
            12'($urandom & $urandom & $urandom), 13'($urandom), r[13]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule